// File: doc/BRIEF.md
# Timer Compare Channel

One compare channel of a general-purpose timer. The channel watches an external counter value and its count direction, compares the count against a 16-bit compare value, and from that builds a reference waveform. The reference is passed through a polarity and enable stage to produce the output pin. A sticky match flag records every equality between count and compare value until it is cleared.

Configuration arrives as three write strobes. The first writes a mode byte that holds the waveform mode and the preload, fast and clear-enable flags. The second writes the compare value. The third writes the output enable and polarity bits. The counter, its update event and the external clear input are driven from outside the block. All state is registered, so every output reflects the inputs that were sampled at the preceding rising clock edge.

Top module: `oc_channel`

## Requirements
- R1: After an asynchronous reset, the following are all 0: the reference, the pin, the match flag, the mode byte, the compare values, the output enable and the polarity.
- R2: The mode is taken from bits 6:4 of the mode byte. In mode 0 (frozen) the reference keeps its value, including on a match.
- R3: In mode 1 a match sets the reference to 1. In mode 2 a match sets it to 0. In mode 3 a match inverts it. Without a match the reference holds in all three modes.
- R4: Mode 4 drives the reference to 0 on every clock. Mode 5 drives it to 1 on every clock.
- R5: Mode 6 (PWM 1): when counting up, the reference is 1 while count < compare and 0 otherwise. When counting down (cnt_down_i=1), it is 0 while count > compare and 1 otherwise.
- R6: Mode 7 (PWM 2) gives the inverse of mode 6 in both count directions.
- R7: Mode byte bit 3 enables preload. With preload enabled, a compare write goes only to the shadow register, and update_i copies the shadow into the active compare value. With preload disabled, a compare write changes the active value at once. If a write with preload disabled and an update arrive together, the written value wins.
- R8: Mode byte bit 7 enables clearing. While it is set, ext_clr_i=1 forces the reference output low from the next clock on, and it stays low until a clock with update_i=1 and no new clear.
- R9: Output control bit 1 is the polarity. With the output enabled, pin_o equals the reference when polarity is 0 and its inverse when polarity is 1.
- R10: Output control bit 0 is the output enable. While it is 0, pin_o equals the polarity bit.
- R11: A clock on which count equals the active compare value sets match_flag_o, in every mode. flag_clr_i clears the flag. If a match and a clear arrive together, the match wins.
- R12: Mode byte bit 2 (fast enable) has no effect on the reference, the pin or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Current counter value |
| cnt_down_i | input | 1 | Count direction, 1 = down |
| update_i | input | 1 | Update event pulse |
| ext_clr_i | input | 1 | External reference clear |
| mode_we_i | input | 1 | Mode byte write strobe |
| mode_byte_i | input | 8 | Mode byte: [7] clear enable, [6:4] mode, [3] preload, [2] fast |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | 16 | Compare value write data |
| out_we_i | input | 1 | Output control write strobe |
| out_ctrl_i | input | 2 | Output control: [1] polarity, [0] enable |
| flag_clr_i | input | 1 | Match flag clear |
| ref_o | output | 1 | Reference waveform after clearing |
| pin_o | output | 1 | Output pin |
| match_flag_o | output | 1 | Sticky match flag |

## Verification
The hardest state to reach from the ports is the set of timing overlaps between the four sources of change: a compare write, an update, an external clear, and a match. Examples are a preloaded write in the same cycle as an update, a clear raised while an update arrives, and a flag clear that lands on a match. The random phase runs the counter up and down over a narrow 0 to 15 window and draws compare values from that same window, so matches happen often. It fires every strobe independently with moderate probability, so these coincidences occur many times. Directed phases then force the preload, clear, PWM boundary and fast-bit cases in isolation.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_FROZEN   = 3'd0,
    OC_SET      = 3'd1,
    OC_CLR      = 3'd2,
    OC_TOG      = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM_A    = 3'd6,
    OC_PWM_B    = 3'd7
  } oc_mode_e;

  localparam int unsigned MB_CE   = 7;
  localparam int unsigned MB_MODE = 4;
  localparam int unsigned MB_PE   = 3;
  localparam int unsigned OUT_EN  = 0;
  localparam int unsigned OUT_POL = 1;
endpackage

// File: rtl/oc_cmp_regs.sv
module oc_cmp_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         preload_i,
  input  logic         update_i,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we_i) shadow_q <= wdata_i;
      if (we_i && !preload_i) active_q <= wdata_i;
      else if (update_i)      active_q <= shadow_q;
    end
  end

  assign active_o = active_q;

  a_r7_preload_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_i && !update_i) |=> $stable(active_q));
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  oc_mode_e     mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cnt_down_i,
  input  logic [W-1:0] cmp_i,
  input  logic         clr_en_i,
  input  logic         ext_clr_i,
  input  logic         update_i,
  output logic         match_o,
  output logic         ref_o
);
  logic ref_q, ref_d, clr_q, pwm_a;

  assign match_o = (cnt_i == cmp_i);
  // down count: active unless count is above compare
  assign pwm_a   = cnt_down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);

  always_comb begin
    ref_d = ref_q;
    unique case (mode_i)
      OC_FROZEN:   ref_d = ref_q;
      OC_SET:      if (match_o) ref_d = 1'b1;
      OC_CLR:      if (match_o) ref_d = 1'b0;
      OC_TOG:      if (match_o) ref_d = ~ref_q;
      OC_FORCE_LO: ref_d = 1'b0;
      OC_FORCE_HI: ref_d = 1'b1;
      OC_PWM_A:    ref_d = pwm_a;
      OC_PWM_B:    ref_d = ~pwm_a;
      default:     ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      if (clr_en_i && ext_clr_i) clr_q <= 1'b1;
      else if (update_i)         clr_q <= 1'b0;
    end
  end

  assign ref_o = ref_q & ~clr_q;

  a_r2_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_FROZEN) |=> $stable(ref_q));
  a_r4_force_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_FORCE_LO) |=> !ref_o);
  a_r4_force_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_FORCE_HI) |=> ref_q);
  a_r8_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && ext_clr_i) |=> !ref_o);
endmodule

// File: rtl/oc_pin_stage.sv
module oc_pin_stage (
  input  logic ref_i,
  input  logic en_i,
  input  logic pol_i,
  output logic pin_o
);
  assign pin_o = en_i ? (ref_i ^ pol_i) : pol_i;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         cnt_down_i,
  input  logic         update_i,
  input  logic         ext_clr_i,
  input  logic         mode_we_i,
  input  logic [7:0]   mode_byte_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         out_we_i,
  input  logic [1:0]   out_ctrl_i,
  input  logic         flag_clr_i,
  output logic         ref_o,
  output logic         pin_o,
  output logic         match_flag_o
);
  oc_mode_e     mode_q;
  logic         pe_q, ce_q, en_q, pol_q, flag_q, match;
  logic [W-1:0] cmp_act;
  logic         unused_fast;

  // fast enable has no trigger path to speed up here
  assign unused_fast = ^{mode_byte_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OC_FROZEN;
      pe_q   <= 1'b0;
      ce_q   <= 1'b0;
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (mode_we_i) begin
        mode_q <= oc_mode_e'(mode_byte_i[MB_MODE +: 3]);
        pe_q   <= mode_byte_i[MB_PE];
        ce_q   <= mode_byte_i[MB_CE];
      end
      if (out_we_i) begin
        en_q  <= out_ctrl_i[OUT_EN];
        pol_q <= out_ctrl_i[OUT_POL];
      end
      if (match)           flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  oc_cmp_regs #(.W(W)) i_cmp (
    .clk_i, .rst_ni,
    .we_i      (cmp_we_i),
    .wdata_i   (cmp_wdata_i),
    .preload_i (pe_q),
    .update_i,
    .active_o  (cmp_act)
  );

  oc_ref_gen #(.W(W)) i_ref (
    .clk_i, .rst_ni,
    .mode_i     (mode_q),
    .cnt_i,
    .cnt_down_i,
    .cmp_i      (cmp_act),
    .clr_en_i   (ce_q),
    .ext_clr_i,
    .update_i,
    .match_o    (match),
    .ref_o
  );

  oc_pin_stage i_pin (
    .ref_i (ref_o),
    .en_i  (en_q),
    .pol_i (pol_q),
    .pin_o
  );

  assign match_flag_o = flag_q;

  a_r11_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> match_flag_o);
  a_r11_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !match) |=> !match_flag_o);
endmodule

// File: tb/test_oc_channel.sv
module test_oc_channel;
  localparam int unsigned W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] cnt = '0, cdata = '0;
  logic dn = 0, upd = 0, eclr = 0, mwe = 0, cwe = 0, ewe = 0, fclr = 0;
  logic [7:0] mbyte = '0;
  logic [1:0] ebits = '0;
  logic ref_o, pin_o, flag_o;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "";
  bit done = 0;

  // reference model state
  logic [2:0] m_mode; logic m_pe, m_ce, m_en, m_pol, m_ref, m_clr, m_flag;
  logic [W-1:0] m_sh, m_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_channel #(.W(W)) i_oc_channel (
    .clk_i(clk), .rst_ni, .cnt_i(cnt), .cnt_down_i(dn), .update_i(upd),
    .ext_clr_i(eclr), .mode_we_i(mwe), .mode_byte_i(mbyte), .cmp_we_i(cwe),
    .cmp_wdata_i(cdata), .out_we_i(ewe), .out_ctrl_i(ebits), .flag_clr_i(fclr),
    .ref_o, .pin_o, .match_flag_o(flag_o)
  );

  task automatic model_reset();
    m_mode = 0; m_pe = 0; m_ce = 0; m_en = 0; m_pol = 0;
    m_ref = 0; m_clr = 0; m_flag = 0; m_sh = '0; m_act = '0;
  endtask

  function automatic logic pwm1(logic [W-1:0] c, logic [W-1:0] k, logic d);
    return d ? (c <= k) : (c < k);
  endfunction

  task automatic model_step();
    logic mt, nref, nclr, nflag;
    logic [W-1:0] nact;
    mt = (cnt == m_act);
    case (m_mode)
      3'd0: nref = m_ref;
      3'd1: nref = mt ? 1'b1 : m_ref;
      3'd2: nref = mt ? 1'b0 : m_ref;
      3'd3: nref = mt ? ~m_ref : m_ref;
      3'd4: nref = 1'b0;
      3'd5: nref = 1'b1;
      3'd6: nref = pwm1(cnt, m_act, dn);
      default: nref = ~pwm1(cnt, m_act, dn);
    endcase
    nclr  = (m_ce && eclr) ? 1'b1 : (upd ? 1'b0 : m_clr);
    nflag = mt ? 1'b1 : (fclr ? 1'b0 : m_flag);
    nact  = (cwe && !m_pe) ? cdata : (upd ? m_sh : m_act);
    if (cwe) m_sh = cdata;
    m_act = nact; m_ref = nref; m_clr = nclr; m_flag = nflag;
    if (mwe) begin m_mode = mbyte[6:4]; m_pe = mbyte[3]; m_ce = mbyte[7]; end
    if (ewe) begin m_en = ebits[0]; m_pol = ebits[1]; end
  endtask

  task automatic cmp1(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string mode_req(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3: return "R3";
      3'd4, 3'd5: return "R4";
      3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare_all(logic [2:0] mode_used);
    logic re;
    re = m_ref & ~m_clr;
    cmp1(cur_req != "" ? cur_req : (m_clr ? "R8" : mode_req(mode_used)), "ref", ref_o, re);
    cmp1(m_en ? "R9" : "R10", "pin", pin_o, m_en ? (re ^ m_pol) : m_pol);
    cmp1("R11", "flag", flag_o, m_flag);
  endtask

  task automatic tick();
    logic [2:0] mu;
    @(posedge clk);
    mu = m_mode;
    model_step();
    @(negedge clk);
    compare_all(mu);
  endtask

  task automatic idle_strobes();
    upd = 0; eclr = 0; mwe = 0; cwe = 0; ewe = 0; fclr = 0;
  endtask

  task automatic wr_mode(logic [7:0] b);
    idle_strobes(); mwe = 1; mbyte = b; tick(); mwe = 0;
  endtask

  task automatic wr_cmp(logic [W-1:0] v);
    idle_strobes(); cwe = 1; cdata = v; tick(); cwe = 0;
  endtask

  task automatic wr_out(logic [1:0] v);
    idle_strobes(); ewe = 1; ebits = v; tick(); ewe = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R1: reset state before and after release
    cmp1("R1", "ref", ref_o, 1'b0);
    cmp1("R1", "pin", pin_o, 1'b0);
    cmp1("R1", "flag", flag_o, 1'b0);
    rst_ni = 1;
    cnt = 16'd7;
    cur_req = "R1";
    tick();
    cur_req = "";

    // R4/R9/R10: forced levels with both polarities and enable
    wr_mode(8'h50); tick();
    wr_out(2'b01); tick();
    wr_out(2'b11); tick();
    wr_mode(8'h40); tick();
    wr_out(2'b10); tick();
    wr_out(2'b01);

    // R3: set / clear / toggle around a match at 5
    wr_cmp(16'd5);
    for (int m = 1; m <= 3; m++) begin
      wr_mode(8'(m << 4));
      for (int c = 3; c <= 7; c++) begin cnt = 16'(c); tick(); end
    end

    // R5/R6: PWM boundaries in both directions
    for (int m = 6; m <= 7; m++) begin
      wr_mode(8'(m << 4));
      for (int d = 0; d <= 1; d++) begin
        dn = d[0];
        for (int c = 3; c <= 7; c++) begin cnt = 16'(c); tick(); end
      end
    end
    dn = 0;

    // R12: fast bit set, same PWM sweep
    cur_req = "R12";
    wr_mode(8'h64);
    for (int c = 3; c <= 7; c++) begin cnt = 16'(c); tick(); end
    cur_req = "";

    // R7: preload holds new value until update; write+update with preload off
    cur_req = "R7";
    wr_mode(8'h68);
    cnt = 16'd12;
    wr_cmp(16'd10);
    for (int c = 8; c <= 12; c++) begin cnt = 16'(c); tick(); end
    upd = 1; tick(); upd = 0;
    for (int c = 8; c <= 12; c++) begin cnt = 16'(c); tick(); end
    wr_mode(8'h60);
    cwe = 1; cdata = 16'd9; upd = 1; tick(); idle_strobes();
    for (int c = 8; c <= 12; c++) begin cnt = 16'(c); tick(); end

    // R8: clear with enable, released by update only
    cur_req = "R8";
    wr_mode(8'hD0);
    eclr = 1; tick(); eclr = 0;
    tick(); tick();
    upd = 1; tick(); upd = 0; tick();
    eclr = 1; upd = 1; tick(); idle_strobes(); tick();
    upd = 1; tick(); upd = 0; tick();
    wr_mode(8'h50);
    eclr = 1; tick(); eclr = 0; tick();

    // R11: clear and match coinciding
    cur_req = "R11";
    wr_cmp(16'd4);
    cnt = 16'd4; tick();
    cnt = 16'd4; fclr = 1; tick();
    cnt = 16'd2; tick(); fclr = 0; tick();
    cur_req = "";

    // random phase
    cnt = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 31) == 0) dn = ~dn;
      if (dn) cnt = (cnt == 0) ? 16'd15 : cnt - 1'b1;
      else    cnt = (cnt == 16'd15) ? 16'd0 : cnt + 1'b1;
      upd   = ($urandom_range(0, 7) == 0);
      eclr  = ($urandom_range(0, 15) == 0);
      fclr  = ($urandom_range(0, 5) == 0);
      mwe   = ($urandom_range(0, 39) == 0);
      mbyte = 8'($urandom());
      cwe   = ($urandom_range(0, 9) == 0);
      cdata = 16'($urandom_range(0, 15));
      ewe   = ($urandom_range(0, 49) == 0);
      ebits = 2'($urandom());
      tick();
    end
    idle_strobes();
    done = 1;
    summary();
  end
endmodule